// File: doc/BRIEF.md
# Voice Group Trigger Controller

This block turns four trigger inputs and one strobe input into start and stop commands for a voice playback engine. All inputs are filtered by a debouncer that counts sample-rate enable ticks, not system clocks. The filtered inputs are then decoded according to a chip-wide mode. In key mode, a fixed table of twelve input combinations selects a voice group, and the strobe input steps through the groups one press at a time. In parallel mode, the four inputs form a binary group address that is captured when the strobe rises.

Each of the twelve groups carries its own three options: edge or level triggering, holdable or unholdable, and retriggerable or not. These options decide what happens when a trigger is released, when the engine reports the end of a group, and when a new trigger arrives during playback. A halt input stops playback at once. The engine returns a one-cycle done pulse at the end of each group.

Top module: `voice_trig_ctrl`

## Requirements
- R1: In key mode (`par_mode_i`=0), `sel_i` bit 0 is the first trigger input and bit 3 the fourth. The codes 0001, 0010, 0100 and 1000 select groups 1 to 4. The codes 0011, 0110, 1100 and 1001 select groups 5 to 8. The codes 0111, 1110, 1101 and 1011 select groups 9 to 12. A change of the filtered inputs to a listed code is a trigger for that group.
- R2: In key mode, the codes 0000, 0101, 1010 and 1111 match no group and start nothing.
- R3: In parallel mode (`par_mode_i`=1), the filtered `sel_i` is read as an unsigned number when the filtered `strb_i` rises. Values 1 to 12 trigger that group. Values 0 and 13 to 15 are ignored. A change of `sel_i` without a strobe rise starts nothing.
- R4: While idle, a new input pattern takes effect only after it has been seen unchanged on DEB_TICKS consecutive `tick_i` pulses. DEB_TICKS-1 pulses are not enough.
- R5: While a group is playing, a new input pattern needs RETRIG_TICKS pulses of `tick_i`. RETRIG_TICKS-1 pulses are not enough.
- R6: A trigger during playback restarts playback with the new group only if that group's retrigger option is set. Otherwise it is ignored, and `grp_o` keeps the playing group.
- R7: In key mode, a filtered strobe rise while idle starts the next group of the sequence 1, 2, …, 12, 1, …. A strobe rise during playback is ignored and does not advance the sequence.
- R8: For a level, holdable group started from the trigger inputs, releasing its input code ends playback at once: `stop_o` pulses and `grp_o` returns to 0.
- R9: For a level group, a `done_i` while its code is still held restarts the same group. A level, unholdable group whose code has been released ends on `done_i` without a `stop_o`.
- R10: For an edge group, `done_i` ends playback even while the input is held. The hold option has no effect on an edge group.
- R11: `halt_i` high stops playback in the next cycle: `stop_o` pulses if a group was playing, and `grp_o` becomes 0. Triggers that complete filtering while `halt_i` is high are dropped.
- R12: After reset, `start_o`, `stop_o` and `grp_o` are 0, and the sequence in R7 begins at group 1.
- R13: `start_o` is a one-cycle pulse. During that pulse, `grp_o` carries the started group (1 to 12). `grp_o` holds that group while it plays and is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample-rate enable, one cycle per sample |
| par_mode_i | input | 1 | 0 selects key mode, 1 selects parallel mode |
| sel_i | input | 4 | Trigger inputs; bit 0 is the first input |
| strb_i | input | 1 | Strobe in parallel mode, sequential step in key mode |
| halt_i | input | 1 | Stop playback immediately |
| done_i | input | 1 | Engine finished the current group |
| opt_edge_i | input | 12 | Per group: 1 for edge, 0 for level; bit g-1 belongs to group g |
| opt_hold_i | input | 12 | Per group: 1 for holdable |
| opt_retrig_i | input | 12 | Per group: 1 for retriggerable |
| start_o | output | 1 | Start command pulse |
| stop_o | output | 1 | Stop command pulse |
| grp_o | output | 4 | Current group number, 0 when idle |

## Verification
The bench walks every 4-bit code in both modes. A decoder that read the key table as binary, or accepted the unused codes 0, 13, 14 and 15, would start the wrong group or start one where none is expected. It probes the debounce window one tick short of each threshold. A design that used the idle threshold during playback, or counted clocks instead of ticks, would start early. Directed cases check that a non-retriggerable press leaves the playing group alone, and that a level holdable release stops at once while an unholdable release waits for done. They also check that an edge group never loops, that the sequential pointer wraps after group 12 and does not advance on a press during playback, and that a trigger arriving while halt is high is dropped instead of deferred.

// File: rtl/voice_trig_pkg.sv
package voice_trig_pkg;
  localparam int unsigned NUM_GRP = 12;
  localparam int unsigned GRP_W   = 4;
  localparam int unsigned IN_W    = 4;

  typedef logic [GRP_W-1:0] grp_t;

  // bit 0 = first trigger input
  function automatic grp_t key_decode(input logic [IN_W-1:0] s);
    grp_t g;
    case (s)
      4'b0001: g = 4'd1;
      4'b0010: g = 4'd2;
      4'b0100: g = 4'd3;
      4'b1000: g = 4'd4;
      4'b0011: g = 4'd5;
      4'b0110: g = 4'd6;
      4'b1100: g = 4'd7;
      4'b1001: g = 4'd8;
      4'b0111: g = 4'd9;
      4'b1110: g = 4'd10;
      4'b1101: g = 4'd11;
      4'b1011: g = 4'd12;
      default: g = '0;
    endcase
    return g;
  endfunction

  function automatic grp_t par_decode(input logic [IN_W-1:0] s);
    return (s != '0 && s <= IN_W'(NUM_GRP)) ? grp_t'(s) : '0;
  endfunction
endpackage

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int unsigned W      = 5,
  parameter int unsigned DEB    = 128,  // must be >= 2
  parameter int unsigned RETRIG = 192   // must be >= DEB
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         slow_i,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] stab_o
);
  localparam int unsigned CW = $clog2(RETRIG + 1);

  logic [W-1:0]  cand_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;

  assign thr = slow_i ? CW'(RETRIG) : CW'(DEB);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= '0;
      stab_o <= '0;
    end else if (tick_i) begin
      if (raw_i != cand_q) begin
        cand_q <= raw_i;
        cnt_q  <= CW'(1);
      end else begin
        if (int'(cnt_q) < int'(RETRIG)) cnt_q <= cnt_q + 1'b1;
        // commit once the run passes the active threshold
        if (int'(cnt_q) + 1 >= int'(thr)) stab_o <= cand_q;
      end
    end
  end
endmodule

// File: rtl/trig_decode.sv
module trig_decode
  import voice_trig_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          par_mode_i,
  input  logic [IN_W:0] stab_i,
  output logic          trig_v_o,
  output grp_t          trig_grp_o,
  output logic          seq_v_o,
  output grp_t          key_grp_o,
  output logic          strb_o
);
  logic [IN_W:0] prev_q;
  grp_t          key_prv, par_grp;
  logic          strb_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stab_i;
  end

  assign key_grp_o = key_decode(stab_i[IN_W-1:0]);
  assign key_prv   = key_decode(prev_q[IN_W-1:0]);
  assign par_grp   = par_decode(stab_i[IN_W-1:0]);
  assign strb_rise = stab_i[IN_W] & ~prev_q[IN_W];
  assign strb_o    = stab_i[IN_W];

  always_comb begin
    trig_v_o   = 1'b0;
    trig_grp_o = '0;
    seq_v_o    = 1'b0;
    if (par_mode_i) begin
      if (strb_rise && par_grp != '0) begin
        trig_v_o   = 1'b1;
        trig_grp_o = par_grp;
      end
    end else if (key_grp_o != '0 && key_grp_o != key_prv) begin
      trig_v_o   = 1'b1;
      trig_grp_o = key_grp_o;
    end else if (strb_rise) begin
      seq_v_o = 1'b1;
    end
  end
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import voice_trig_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               par_mode_i,
  input  logic               halt_i,
  input  logic               done_i,
  input  logic               trig_v_i,
  input  grp_t               trig_grp_i,
  input  logic               seq_v_i,
  input  grp_t               key_grp_i,
  input  logic               strb_i,
  input  logic [NUM_GRP-1:0] opt_edge_i,
  input  logic [NUM_GRP-1:0] opt_hold_i,
  input  logic [NUM_GRP-1:0] opt_retrig_i,
  output logic               play_o,
  output logic               start_o,
  output logic               stop_o,
  output grp_t               grp_o
);
  logic play_q, seq_q, start_q, stop_q;
  grp_t cur_q, ptr_q;
  logic play_d, seq_d, start_d, stop_d;
  grp_t cur_d, ptr_d;

  logic [NUM_GRP-1:0] trig_oh, cur_oh;
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_oh
    assign trig_oh[g] = (trig_grp_i == grp_t'(g + 1));
    assign cur_oh[g]  = (cur_q == grp_t'(g + 1));
  end

  logic lvl, hld, rtg, held, accept;
  assign lvl    = |(cur_oh & ~opt_edge_i);
  assign hld    = |(cur_oh & opt_hold_i);
  assign rtg    = |(trig_oh & opt_retrig_i);
  assign held   = !seq_q && (par_mode_i ? strb_i : (key_grp_i == cur_q));
  assign accept = trig_v_i && (!play_q || rtg);

  always_comb begin
    play_d  = play_q;
    seq_d   = seq_q;
    cur_d   = cur_q;
    ptr_d   = ptr_q;
    start_d = 1'b0;
    stop_d  = 1'b0;
    if (halt_i) begin
      stop_d = play_q;
      play_d = 1'b0;
      seq_d  = 1'b0;
      cur_d  = '0;
    end else if (accept) begin
      start_d = 1'b1;
      play_d  = 1'b1;
      seq_d   = 1'b0;
      cur_d   = trig_grp_i;
    end else if (seq_v_i && !play_q) begin
      start_d = 1'b1;
      play_d  = 1'b1;
      seq_d   = 1'b1;
      cur_d   = ptr_q;
      ptr_d   = (ptr_q == grp_t'(NUM_GRP)) ? grp_t'(1) : ptr_q + 1'b1;
    end else if (play_q && lvl && hld && !seq_q && !held) begin
      stop_d = 1'b1;
      play_d = 1'b0;
      cur_d  = '0;
    end else if (play_q && done_i) begin
      if (lvl && held) begin
        start_d = 1'b1;
      end else begin
        play_d = 1'b0;
        seq_d  = 1'b0;
        cur_d  = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_q  <= 1'b0;
      seq_q   <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      cur_q   <= '0;
      ptr_q   <= grp_t'(1);
    end else begin
      play_q  <= play_d;
      seq_q   <= seq_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      cur_q   <= cur_d;
      ptr_q   <= ptr_d;
    end
  end

  assign play_o  = play_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign grp_o   = cur_q;
endmodule

// File: rtl/voice_trig_ctrl.sv
module voice_trig_ctrl
  import voice_trig_pkg::*;
#(
  parameter int unsigned DEB_TICKS    = 128,
  parameter int unsigned RETRIG_TICKS = 192
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               par_mode_i,
  input  logic [IN_W-1:0]    sel_i,
  input  logic               strb_i,
  input  logic               halt_i,
  input  logic               done_i,
  input  logic [NUM_GRP-1:0] opt_edge_i,
  input  logic [NUM_GRP-1:0] opt_hold_i,
  input  logic [NUM_GRP-1:0] opt_retrig_i,
  output logic               start_o,
  output logic               stop_o,
  output logic [GRP_W-1:0]   grp_o
);
  logic [IN_W:0] stab;
  logic          play, trig_v, seq_v, strb_f;
  grp_t          trig_grp, key_grp;

  trig_debounce #(
    .W(IN_W + 1), .DEB(DEB_TICKS), .RETRIG(RETRIG_TICKS)
  ) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .slow_i (play),
    .raw_i  ({strb_i, sel_i}),
    .stab_o (stab)
  );

  trig_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .par_mode_i (par_mode_i),
    .stab_i     (stab),
    .trig_v_o   (trig_v),
    .trig_grp_o (trig_grp),
    .seq_v_o    (seq_v),
    .key_grp_o  (key_grp),
    .strb_o     (strb_f)
  );

  trig_ctrl u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .par_mode_i   (par_mode_i),
    .halt_i       (halt_i),
    .done_i       (done_i),
    .trig_v_i     (trig_v),
    .trig_grp_i   (trig_grp),
    .seq_v_i      (seq_v),
    .key_grp_i    (key_grp),
    .strb_i       (strb_f),
    .opt_edge_i   (opt_edge_i),
    .opt_hold_i   (opt_hold_i),
    .opt_retrig_i (opt_retrig_i),
    .play_o       (play),
    .start_o      (start_o),
    .stop_o       (stop_o),
    .grp_o        (grp_o)
  );
endmodule

// File: rtl/voice_trig_chk.sv
module voice_trig_chk
  import voice_trig_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_i,
  input logic             start_o,
  input logic             stop_o,
  input logic [GRP_W-1:0] grp_o
);
  a_r13_start_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (grp_o != '0 && grp_o <= GRP_W'(NUM_GRP)));

  a_r11_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (!start_o && grp_o == '0));

  a_r8_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> grp_o == '0);

  a_r13_stop_after_play: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> $past(grp_o) != '0);

  a_r11_stop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o);
endmodule

bind voice_trig_ctrl voice_trig_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .halt_i  (halt_i),
  .start_o (start_o),
  .stop_o  (stop_o),
  .grp_o   (grp_o)
);

// File: tb/sim_voice_trig_ctrl.sv
module sim_voice_trig_ctrl;
  localparam int DEB = 4;
  localparam int RTG = 6;
  // {code, expected group}
  localparam logic [7:0] KEY_VEC [15] = '{
    8'h11, 8'h22, 8'h35, 8'h43, 8'h50, 8'h66, 8'h79, 8'h84,
    8'h98, 8'hA0, 8'hBC, 8'hC7, 8'hDB, 8'hEA, 8'hF0};

  logic clk = 0, rst_n = 0, tick = 0, par = 0, strb = 0, halt = 0, done = 0;
  logic [3:0]  sel = '0;
  logic [11:0] edge_v = '1, hold_v = '0, rtg_v = '0;
  logic        start, stop;
  logic [3:0]  grp;
  int n_chk = 0, n_err = 0, n_start = 0, n_stop = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  voice_trig_ctrl #(.DEB_TICKS(DEB), .RETRIG_TICKS(RTG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .par_mode_i(par),
    .sel_i(sel), .strb_i(strb), .halt_i(halt), .done_i(done),
    .opt_edge_i(edge_v), .opt_hold_i(hold_v), .opt_retrig_i(rtg_v),
    .start_o(start), .stop_o(stop), .grp_o(grp));

  always @(posedge clk) begin
    if (start) n_start++;
    if (stop)  n_stop++;
  end

  task automatic settle(); repeat (4) @(negedge clk); endtask
  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1; @(negedge clk); tick = 0; end
    settle();
  endtask
  task automatic pulse_done();
    @(negedge clk); done = 1; @(negedge clk); done = 0; settle();
  endtask
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R12 reset start_o", int'(start), 0);
    chk("R12 reset stop_o", int'(stop), 0);
    chk("R12 reset grp_o", int'(grp), 0);

    // R1/R2 key table walk, all groups edge
    for (int i = 0; i < 15; i++) begin
      logic [3:0] code, exp;
      code = KEY_VEC[i][7:4];
      exp  = KEY_VEC[i][3:0];
      s0 = n_start;
      sel = code;
      ticks(DEB);
      chk(exp != 0 ? "R1 key start" : "R2 unused code", n_start - s0, exp != 0 ? 1 : 0);
      chk(exp != 0 ? "R1 key group" : "R2 unused code grp", int'(grp), int'(exp));
      sel = '0;
      ticks(RTG);
      pulse_done();
      chk("R10 edge ends on done", int'(grp), 0);
    end

    // R4 debounce boundary
    s0 = n_start;
    sel = 4'b0001;
    ticks(DEB - 1);
    chk("R4 short of debounce", n_start - s0, 0);
    ticks(1);
    chk("R4 debounce met", n_start - s0, 1);
    sel = '0; ticks(RTG); pulse_done();

    // R3 parallel mode
    par = 1;
    for (int c = 0; c < 16; c++) begin
      s0 = n_start;
      sel = 4'(c);
      ticks(DEB);
      chk("R3 address without strobe", n_start - s0, 0);
      strb = 1;
      ticks(DEB);
      chk("R3 strobe start", n_start - s0, (c >= 1 && c <= 12) ? 1 : 0);
      chk("R3 strobe group", int'(grp), (c >= 1 && c <= 12) ? c : 0);
      strb = 0; sel = '0;
      ticks(RTG);
      pulse_done();
    end
    par = 0; ticks(DEB);

    // R7 sequential stepping with wrap
    for (int i = 0; i < 13; i++) begin
      s0 = n_start;
      strb = 1; ticks(DEB);
      chk("R7 sequential start", n_start - s0, 1);
      chk("R7 sequential group", int'(grp), (i % 12) + 1);
      strb = 0; ticks(RTG);
      pulse_done();
    end
    strb = 1; ticks(DEB);
    chk("R7 next group after wrap", int'(grp), 2);
    strb = 0; ticks(RTG);
    s0 = n_start;
    strb = 1; ticks(RTG);
    chk("R7 press while playing ignored", n_start - s0, 0);
    chk("R7 group kept", int'(grp), 2);
    strb = 0; ticks(RTG); pulse_done();
    strb = 1; ticks(DEB);
    chk("R7 pointer not advanced by ignored press", int'(grp), 3);
    strb = 0; ticks(RTG); pulse_done();

    // R5/R6 retrigger
    rtg_v = 12'b0000_0000_0010;
    sel = 4'b0001; ticks(DEB);
    chk("R6 base start", int'(grp), 1);
    sel = '0; ticks(RTG);
    s0 = n_start;
    sel = 4'b0100; ticks(RTG);
    chk("R6 non-retrig ignored", n_start - s0, 0);
    chk("R6 group kept", int'(grp), 1);
    sel = '0; ticks(RTG);
    sel = 4'b0010; ticks(RTG - 1);
    chk("R5 short of retrigger time", n_start - s0, 0);
    ticks(1);
    chk("R5 retrigger time met", n_start - s0, 1);
    chk("R6 retrigger group", int'(grp), 2);
    sel = '0; ticks(RTG); pulse_done();
    rtg_v = '0;

    // R8 level holdable release
    edge_v[3] = 0; hold_v[3] = 1;
    sel = 4'b1000; ticks(DEB);
    chk("R8 start", int'(grp), 4);
    p0 = n_stop;
    sel = '0; ticks(RTG);
    chk("R8 release stops", n_stop - p0, 1);
    chk("R8 idle after stop", int'(grp), 0);

    // R9 level unholdable loop and end
    edge_v[4] = 0; hold_v[4] = 0;
    sel = 4'b0011; ticks(DEB);
    s0 = n_start; p0 = n_stop;
    pulse_done();
    chk("R9 held restart", n_start - s0, 1);
    chk("R9 held group", int'(grp), 5);
    sel = '0; ticks(RTG);
    chk("R9 release no stop", n_stop - p0, 0);
    chk("R9 still playing", int'(grp), 5);
    pulse_done();
    chk("R9 ends on done", int'(grp), 0);
    chk("R9 no restart", n_start - s0, 1);

    // R10 edge hold has no effect
    hold_v[5] = 1;
    sel = 4'b0110; ticks(DEB);
    s0 = n_start;
    pulse_done();
    chk("R10 edge no loop", n_start - s0, 0);
    chk("R10 edge idle", int'(grp), 0);
    sel = '0; ticks(DEB);

    // R11 halt
    sel = 4'b0001; ticks(DEB);
    p0 = n_stop;
    @(negedge clk); halt = 1;
    settle();
    chk("R11 halt stop pulse", n_stop - p0, 1);
    chk("R11 halt idle", int'(grp), 0);
    sel = '0; ticks(DEB);
    s0 = n_start;
    sel = 4'b0010; ticks(DEB);
    @(negedge clk); halt = 0;
    settle();
    chk("R11 trigger under halt dropped", n_start - s0, 0);
    sel = '0; ticks(DEB);
    sel = 4'b0010; ticks(DEB);
    chk("R13 start after halt", int'(grp), 2);
    sel = '0; ticks(RTG); pulse_done();

    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule